// File: doc/BRIEF.md
# Command Set Claim Arbiter with In-Flight Address Conflict Check

This block decides which command set of a serving group a new immediate-transfer request may take. The sets share one global index space. Each group is a contiguous range of indices given by an offset and a count. A request carries up to `SLOTS` target addresses, each with its own enable bit. The block holds a busy bitmap over the whole index space. For every busy set it also keeps the addresses and enable mask that the set was granted with.

On a request, the block compares every enabled request address with every enabled stored address of every busy set in the serving group. Any match refuses the request with a busy response. With no match, the block grants the lowest-indexed free set of the group, records the request's addresses there and marks the set busy. When the group has no free set, the request is refused. The decision, the response and the bitmap update happen on the same clock edge, so two requests can never claim the same set.

A release input ends a transfer. It clears the busy bit and the stored enable mask of one set, and from then on that set's addresses no longer block new requests. When the immediate-transfer group is configured with zero sets, the wake group serves these requests instead. A controller-busy output reports whether any set of the serving group is in use.

Top module: `set_claim_arb`

## Requirements
- R1: After reset, `busy_map` is all zero and `rsp_valid`, `rsp_grant`, `rsp_busy` and `ctrl_busy` are 0.
- R2: A request with no conflict, arriving while a free set exists, gives `rsp_valid`=1, `rsp_grant`=1, `rsp_busy`=0 in the cycle after the request. In that cycle `rsp_id` is the lowest free index in the serving range, and that bit of `busy_map` is 1.
- R3: If any enabled request address equals any enabled stored address of a busy set in the serving range, the response is `rsp_busy`=1, `rsp_grant`=0, `rsp_id`=0. No bit of `busy_map` is set by that request. Slot positions do not need to match, and the highest slot is compared like any other.
- R4: A request address whose `req_en` bit is 0 never causes a conflict. A stored address whose enable bit was 0 at grant time never causes a conflict.
- R5: When every set in the serving range is busy, a request with no conflict gets `rsp_busy`=1 and `busy_map` is unchanged.
- R6: A release (`rel_valid`=1, `rel_id`) clears that set's busy bit and stored enables at the next edge. A request in the same cycle is decided on the state before the release. Releasing an idle set changes nothing. A cycle without a request gives `rsp_valid`=0.
- R7: `ctrl_busy` is 1 exactly when some set of the serving range is busy.
- R8: With `ACT_CNT`=0, the serving range is the wake range `WAKE_OFF`..`WAKE_OFF+WAKE_CNT-1`, and grants come from that range in ascending order.
- R9: Bits of `busy_map` outside the serving range stay 0.

Request address packing: slot k occupies `req_addr[k*ADDR_W +: ADDR_W]`, and its enable is `req_en[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New claim request this cycle |
| req_en | input | SLOTS | Enable per request address slot |
| req_addr | input | SLOTS*ADDR_W | Packed request target addresses |
| rel_valid | input | 1 | Release a set this cycle |
| rel_id | input | IDW | Global index of the set to release |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_grant | output | 1 | Request granted |
| rsp_busy | output | 1 | Request refused (conflict or group full) |
| rsp_id | output | IDW | Granted set index, 0 when refused |
| busy_map | output | NUM_SETS | Busy bitmap over the global index space |
| ctrl_busy | output | 1 | Some set of the serving group is busy |

## Verification
Requests are tried with several address patterns against busy sets:
- a same-slot match and a cross-slot match, which show that the comparison covers all slot pairs rather than aligned slots only;
- a match in the highest slot, which catches a truncated slot loop;
- a match hidden behind a disabled request slot, and a match hidden behind a disabled stored slot, which separate enable gating from raw address comparison.

Grants are tried after releases in and out of index order, which exposes a wrong lowest-free search. A request arriving in the same cycle as a release, with the group full, shows whether the decision uses the state before the release. A second instance with an empty immediate group shows the wake-range fallback.

// File: rtl/set_claim_pkg.sv
package set_claim_pkg;
   // Bit mask with ones at indices off .. off+cnt-1, up to 64 sets.
   function automatic logic [63:0] range_mask(input int off, input int cnt);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++)
         if (i >= off && i < off + cnt) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/set_claim_conflict.sv
module set_claim_conflict #(
   parameter int NUM_SETS = 6,
   parameter int SLOTS    = 4,
   parameter int ADDR_W   = 8
) (
   input  logic [NUM_SETS-1:0]                        set_busy,
   input  logic [NUM_SETS-1:0][SLOTS-1:0]             st_en,
   input  logic [NUM_SETS-1:0][SLOTS-1:0][ADDR_W-1:0] st_addr,
   input  logic [SLOTS-1:0]                           rq_en,
   input  logic [SLOTS-1:0][ADDR_W-1:0]               rq_addr,
   output logic                                       hit
);
   logic [NUM_SETS-1:0][SLOTS-1:0][SLOTS-1:0] pair_hit;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      for (genvar j = 0; j < SLOTS; j++) begin : g_stored
         for (genvar k = 0; k < SLOTS; k++) begin : g_req
            assign pair_hit[s][j][k] = set_busy[s] && st_en[s][j] && rq_en[k]
                                       && (st_addr[s][j] == rq_addr[k]);
         end
      end
   end

   assign hit = |pair_hit;
endmodule

// File: rtl/set_claim_lowfree.sv
module set_claim_lowfree #(
   parameter int NUM_SETS = 6,
   parameter int IDW      = 3
) (
   input  logic [NUM_SETS-1:0] avail,
   output logic                found,
   output logic [IDW-1:0]      idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_SETS - 1; i >= 0; i--) begin
         if (avail[i]) begin
            found = 1'b1;
            idx   = IDW'(i);
         end
      end
   end
endmodule

// File: rtl/set_claim_arb.sv
module set_claim_arb
   import set_claim_pkg::*;
#(
   parameter int NUM_SETS = 6,
   parameter int SLOTS    = 4,
   parameter int ADDR_W   = 8,
   parameter int ACT_OFF  = 2,
   parameter int ACT_CNT  = 3,
   parameter int WAKE_OFF = 0,
   parameter int WAKE_CNT = 2,
   parameter int IDW      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [SLOTS-1:0]          req_en,
   input  logic [SLOTS*ADDR_W-1:0]   req_addr,
   input  logic                      rel_valid,
   input  logic [IDW-1:0]            rel_id,
   output logic                      rsp_valid,
   output logic                      rsp_grant,
   output logic                      rsp_busy,
   output logic [IDW-1:0]            rsp_id,
   output logic [NUM_SETS-1:0]       busy_map,
   output logic                      ctrl_busy
);
   localparam int SRV_OFF = (ACT_CNT == 0) ? WAKE_OFF : ACT_OFF;
   localparam int SRV_CNT = (ACT_CNT == 0) ? WAKE_CNT : ACT_CNT;
   localparam logic [63:0] MASK64 = range_mask(SRV_OFF, SRV_CNT);
   localparam logic [NUM_SETS-1:0] SRV_MASK = MASK64[NUM_SETS-1:0];

   if (NUM_SETS < 1 || NUM_SETS > 64) begin : g_bad_sets
      $error("NUM_SETS must be 1..64");
   end
   if (SRV_CNT < 1 || SRV_OFF < 0 || SRV_OFF + SRV_CNT > NUM_SETS) begin : g_bad_range
      $error("serving group range lies outside the set index space");
   end
   if ((1 << IDW) < NUM_SETS) begin : g_bad_idw
      $error("IDW too narrow for NUM_SETS");
   end
   if (SLOTS < 1 || ADDR_W < 1) begin : g_bad_slots
      $error("SLOTS and ADDR_W must be positive");
   end

   logic [SLOTS-1:0][ADDR_W-1:0]               rq_a;
   logic [NUM_SETS-1:0]                        busy_q;
   logic [NUM_SETS-1:0][SLOTS-1:0]             en_q;
   logic [NUM_SETS-1:0][SLOTS-1:0][ADDR_W-1:0] addr_q;
   logic                                       hit, found, take;
   logic [IDW-1:0]                             free_id;
   logic                                       rel_ok;

   assign rq_a = req_addr;

   set_claim_conflict #(.NUM_SETS(NUM_SETS), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_conflict (
      .set_busy (busy_q & SRV_MASK),
      .st_en    (en_q),
      .st_addr  (addr_q),
      .rq_en    (req_en),
      .rq_addr  (rq_a),
      .hit      (hit)
   );

   set_claim_lowfree #(.NUM_SETS(NUM_SETS), .IDW(IDW)) u_lowfree (
      .avail (~busy_q & SRV_MASK),
      .found (found),
      .idx   (free_id)
   );

   assign take   = req_valid && !hit && found;
   assign rel_ok = rel_valid && ({1'b0, rel_id} < (IDW + 1)'(NUM_SETS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= '0;
         en_q      <= '0;
         addr_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_busy  <= 1'b0;
         rsp_id    <= '0;
      end else begin
         if (rel_ok) begin
            busy_q[rel_id] <= 1'b0;
            en_q[rel_id]   <= '0;
         end
         if (take) begin
            busy_q[free_id] <= 1'b1;
            en_q[free_id]   <= req_en;
            addr_q[free_id] <= rq_a;
         end
         rsp_valid <= req_valid;
         rsp_grant <= take;
         rsp_busy  <= req_valid && !take;
         rsp_id    <= take ? free_id : '0;
      end
   end

   assign busy_map  = busy_q;
   assign ctrl_busy = |(busy_q & SRV_MASK);

   // R1, R2, R3: a response is exactly one of grant or busy
   a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_grant, rsp_busy}) && ((rsp_grant || rsp_busy) == rsp_valid));

   // R2: a granted set is marked busy when the grant appears
   a_r2_grant_marks: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> busy_map[rsp_id]);

   // R8, R9: a grant lies inside the serving range
   a_r8_grant_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> (rsp_id >= IDW'(SRV_OFF)) && ({1'b0, rsp_id} < (IDW + 1)'(SRV_OFF + SRV_CNT)));

   // R3, R5: a refusal without a release leaves the bitmap alone
   a_r3_refuse_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_busy && !$past(rel_valid) |-> busy_map == $past(busy_map));

   // R7: an empty bitmap means the controller is idle
   a_r7_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_map == '0) |-> !ctrl_busy);

   // R6: a released set is not busy afterwards unless re-granted at once
   a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rel_ok && !(take && free_id == rel_id) |=> !busy_map[$past(rel_id)]);
endmodule

// File: tb/set_claim_arb_tb.sv
module set_claim_arb_tb;
   localparam int N = 6, S = 4, A = 8, IDW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic            req_valid, rel_valid;
   logic [S-1:0]    req_en;
   logic [S*A-1:0]  req_addr;
   logic [IDW-1:0]  rel_id;
   logic            rsp_valid, rsp_grant, rsp_busy, ctrl_busy;
   logic [IDW-1:0]  rsp_id;
   logic [N-1:0]    busy_map;

   logic            w_req, w_rel;
   logic [S-1:0]    w_en;
   logic [S*A-1:0]  w_addr;
   logic [IDW-1:0]  w_rel_id;
   logic            w_v, w_g, w_b, w_cb;
   logic [IDW-1:0]  w_id;
   logic [N-1:0]    w_map;

   set_claim_arb #(.NUM_SETS(N), .SLOTS(S), .ADDR_W(A), .ACT_OFF(2), .ACT_CNT(3),
                   .WAKE_OFF(0), .WAKE_CNT(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_en(req_en), .req_addr(req_addr),
      .rel_valid(rel_valid), .rel_id(rel_id), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
      .rsp_busy(rsp_busy), .rsp_id(rsp_id), .busy_map(busy_map), .ctrl_busy(ctrl_busy));

   set_claim_arb #(.NUM_SETS(N), .SLOTS(S), .ADDR_W(A), .ACT_OFF(4), .ACT_CNT(0),
                   .WAKE_OFF(1), .WAKE_CNT(2)) u_dut_w (
      .clk(clk), .rst_n(rst_n), .req_valid(w_req), .req_en(w_en), .req_addr(w_addr),
      .rel_valid(w_rel), .rel_id(w_rel_id), .rsp_valid(w_v), .rsp_grant(w_g),
      .rsp_busy(w_b), .rsp_id(w_id), .busy_map(w_map), .ctrl_busy(w_cb));

   typedef struct packed {
      logic           rv;
      logic [S-1:0]   en;
      logic [S*A-1:0] addr;
      logic           lv;
      logic [IDW-1:0] lid;
      logic           ev;
      logic           eg;
      logic [IDW-1:0] eid;
      logic [N-1:0]   emap;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'b0001, 32'h0000_0010, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 6'b000100}, // R2 first grant
      '{1'b1, 4'b0011, 32'h0000_2120, 1'b0, 3'd0, 1'b1, 1'b1, 3'd3, 6'b001100}, // R2 next lowest
      '{1'b1, 4'b0001, 32'h0000_0021, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 6'b001100}, // R3 cross-slot
      '{1'b1, 4'b0010, 32'h0000_1000, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 6'b001100}, // R3 slot1 vs slot0
      '{1'b1, 4'b0001, 32'h0000_1030, 1'b0, 3'd0, 1'b1, 1'b1, 3'd4, 6'b011100}, // R4 disabled req slot
      '{1'b1, 4'b0001, 32'h0000_0040, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 6'b011100}, // R5 group full
      '{1'b1, 4'b0001, 32'h0000_0050, 1'b1, 3'd3, 1'b1, 1'b0, 3'd0, 6'b010100}, // R6 pre-release decision
      '{1'b1, 4'b0001, 32'h0000_0020, 1'b0, 3'd0, 1'b1, 1'b1, 3'd3, 6'b011100}, // R6 released addrs free
      '{1'b0, 4'b0000, 32'h0000_0000, 1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 6'b011000}, // R6 release only
      '{1'b1, 4'b0001, 32'h0000_0010, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 6'b011100}, // R4 disabled stored slot
      '{1'b0, 4'b0000, 32'h0000_0000, 1'b1, 3'd0, 1'b0, 1'b0, 3'd0, 6'b011100}, // R6 idle release, R9
      '{1'b1, 4'b1000, 32'h3000_0000, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 6'b011100}  // R3 highest slot
   };

   int checks = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic rv, input logic [S-1:0] en, input logic [S*A-1:0] ad,
                        input logic lv, input logic [IDW-1:0] lid);
      req_valid = rv; req_en = en; req_addr = ad; rel_valid = lv; rel_id = lid;
      @(negedge clk);
      req_valid = 1'b0; rel_valid = 1'b0;
   endtask

   task automatic wdrive(input logic rv, input logic [S*A-1:0] ad);
      w_req = rv; w_en = 4'b0001; w_addr = ad;
      @(negedge clk);
      w_req = 1'b0;
   endtask

   initial begin
      req_valid = 0; rel_valid = 0; req_en = '0; req_addr = '0; rel_id = '0;
      w_req = 0; w_rel = 0; w_en = '0; w_addr = '0; w_rel_id = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {busy_map, rsp_valid, rsp_grant, rsp_busy, ctrl_busy}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset release", {busy_map, rsp_valid, ctrl_busy}, '0);

      for (int v = 0; v < NV; v++) begin
         drive(VEC[v].rv, VEC[v].en, VEC[v].addr, VEC[v].lv, VEC[v].lid);
         chk($sformatf("R2/R3/R4/R5/R6 vector %0d", v),
             {rsp_valid, rsp_grant, rsp_busy, rsp_id, busy_map},
             {VEC[v].ev, VEC[v].eg, VEC[v].ev & ~VEC[v].eg, VEC[v].eid, VEC[v].emap});
      end
      chk("R7 ctrl_busy with sets in use", ctrl_busy, 1'b1);

      drive(1'b0, '0, '0, 1'b1, 3'd4);
      drive(1'b0, '0, '0, 1'b1, 3'd2);
      drive(1'b0, '0, '0, 1'b1, 3'd3);
      chk("R6 all released", busy_map, '0);
      chk("R7 ctrl_busy idle", ctrl_busy, 1'b0);
      drive(1'b1, 4'b0001, 32'h0000_0030, 1'b0, 3'd0);
      chk("R2 grant lowest after releases", {rsp_grant, rsp_id, busy_map}, {1'b1, 3'd2, 6'b000100});

      wdrive(1'b1, 32'h0000_0001);
      chk("R8 wake fallback first", {w_g, w_id, w_map}, {1'b1, 3'd1, 6'b000010});
      wdrive(1'b1, 32'h0000_0002);
      chk("R8 wake fallback second", {w_g, w_id, w_map}, {1'b1, 3'd2, 6'b000110});
      wdrive(1'b1, 32'h0000_0003);
      chk("R8 wake group full", {w_v, w_g, w_b, w_map}, {3'b101, 6'b000110});
      chk("R7 ctrl_busy follows wake group", w_cb, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule